// File: doc/BRIEF.md
# I2C Slave Address-Matching Controller

This block is the target side of a two-wire serial bus. It watches the clock and data lines, decodes START and STOP conditions, and shifts in the first byte after each START. That byte holds a 7-bit address and a direction bit. The address is compared with a programmable own address and, when enabled, with the broadcast address of all zeros. If it matches and acknowledging is enabled, the block pulls the data line low on the ninth clock. It then receives bytes from the bus master or sends bytes to it, depending on the direction bit.

A host on the chip side sees a receive data register, a transmit data register, a set of event flags and one interrupt line. The host clears the flags with read and write strobes. When the host falls behind, the block holds the bus clock low at the byte boundary and releases it once the host has serviced the pending byte. Both bus lines are open-drain: the block only ever drives a line low, using the `*_oe` outputs.

Top module: `i2c_slave_ctrl`

## Requirements
- R1: After reset every flag output, `evt_irq`, `scl_oe` and `sda_oe` are 0.
- R2: After a START, when the first byte's upper 7 bits (first bit sent is the MSB) equal `own_addr` and `ack_en` is 1, SDA is pulled low for the ninth clock. `flag_addr` is set, and `flag_tra` takes the direction bit (the LSB, 1 = block transmits, 0 = block receives). SDA only changes while the synchronized SCL is low, or when a START or STOP releases it.
- R3: A first byte that does not match is not acknowledged and sets no flag. Every later byte up to the next START or STOP is also ignored: it gets no ACK, and `flag_rxne` and `flag_stopf` stay 0.
- R4: With `ack_en` at 0, a matching address is not acknowledged, `flag_addr` stays 0, and the transaction is ignored.
- R5: The byte 0x00 (all-zero address with the write bit) is acknowledged and sets `flag_addr` only while `gc_en` is 1. With `gc_en` at 0 it is not acknowledged.
- R6: In receive mode each byte appears on `rx_dout` and sets `flag_rxne`. It is acknowledged when `ack_en` is 1 and not acknowledged otherwise. A `rx_rd` pulse clears `flag_rxne`.
- R7: A STOP after an addressed transaction sets `flag_stopf` and clears `flag_tra`. A `stat_rd` pulse clears `flag_addr`, `flag_stopf` and `flag_af`.
- R8: In transmit mode, bytes written by `tx_wr` are sent MSB first. `flag_txe` is 1 while the block transmits and the transmit register is empty. A write clears it, and moving the byte into the shifter at a byte boundary sets it again.
- R9: A master NACK after a transmitted byte sets `flag_af`, and the block leaves SDA released until the next START.
- R10: If `flag_rxne` is still set when the next received byte completes, SCL is held low and `flag_btf` is 1. The byte is neither delivered nor acknowledged until `rx_rd` is pulsed.
- R11: If the transmit register is empty at a transmit byte boundary that follows an ACK, SCL is held low and `flag_btf` is 1 until `tx_wr` is pulsed.
- R12: `evt_irq` is 1 exactly when `evt_ie` is 1 and at least one of `flag_addr`, `flag_rxne`, `flag_txe`, `flag_stopf` or `flag_af` is 1.
- R13: `flag_addr` rises on the third clock edge after the SCL pin falls at the end of the eighth address bit. A `stat_rd` sampled on that same edge does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| scl_oe | output | 1 | 1 pulls the bus clock low (stretch) |
| sda_oe | output | 1 | 1 pulls the bus data line low |
| own_addr | input | DATA_W-1 | Own 7-bit address |
| ack_en | input | 1 | Acknowledge address and received bytes |
| gc_en | input | 1 | Accept the all-zero broadcast address |
| evt_ie | input | 1 | Event interrupt enable |
| tx_wr | input | 1 | Write strobe for the transmit register |
| tx_din | input | DATA_W | Transmit register write data |
| rx_rd | input | 1 | Receive register read strobe |
| rx_dout | output | DATA_W | Last delivered received byte |
| stat_rd | input | 1 | Status read strobe |
| flag_addr | output | 1 | Address matched |
| flag_tra | output | 1 | Direction: 1 = block transmits |
| flag_txe | output | 1 | Transmit register empty in transmit mode |
| flag_rxne | output | 1 | Received byte waiting |
| flag_af | output | 1 | Master NACK seen |
| flag_stopf | output | 1 | STOP ended an addressed transaction |
| flag_btf | output | 1 | Clock held at a byte boundary |
| evt_irq | output | 1 | Event interrupt |

## Verification
Two things can land on the same clock edge: setting the address-match flag when the eighth address bit ends, and a host status read that clears that flag. The bench counts edges from the moment it lowers SCL at the pin. It fires a single-cycle `stat_rd` on exactly the edge where the match is registered, and checks that the flag was still 0 one cycle earlier and is 1 afterwards. A smaller collision is also covered: a `rx_rd` from the host while the bus is waiting on SCL. That case is judged by the held byte staying on `rx_dout` and the new byte being acknowledged only after the release.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_RX,
    ST_RACK,
    ST_RHOLD,
    ST_TX,
    ST_TACK,
    ST_THOLD,
    ST_IGNORE
  } slv_state_t;
endpackage

// File: rtl/i2c_slv_sync.sv
module i2c_slv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ch;
  logic [STAGES-1:0] sda_ch;
  logic              scl_q;
  logic              sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ch <= '1;
      sda_ch <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ch <= {scl_ch[STAGES-2:0], scl_i};
      sda_ch <= {sda_ch[STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s     = scl_ch[STAGES-1];
  assign sda_s     = sda_ch[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_slv_engine.sv
module i2c_slv_engine
  import i2c_slv_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [DATA_W-2:0] own_addr,
  input  logic              ack_en,
  input  logic              gc_en,
  input  logic              tx_full,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              rxne,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              addr_evt,
  output logic              addr_rw,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_byte,
  output logic              tx_take,
  output logic              nack_evt,
  output logic              stop_evt,
  output logic              stall
);
  localparam int CW = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DATA_W);
  localparam logic [CW-1:0] CNT_LAST = CW'(DATA_W - 1);

  slv_state_t        state;
  logic [DATA_W-1:0] sr;
  logic [CW-1:0]     cnt;
  logic              rw_q;
  logic              mack_q;
  logic              active;

  function automatic logic addr_hit(input logic [DATA_W-1:0] ab,
                                    input logic [DATA_W-2:0] own,
                                    input logic gc);
    return (ab[DATA_W-1:1] == own) || (gc && (ab == '0));
  endfunction

  logic byte_done;
  logic hit;
  logic tx_need;
  logic rx_done;

  assign byte_done = scl_fall && (cnt == CNT_FULL);
  assign hit       = addr_hit(sr, own_addr, gc_en);
  assign addr_evt  = (state == ST_ADDR) && byte_done && hit && ack_en;
  assign addr_rw   = sr[0];
  assign tx_need   = scl_fall && (((state == ST_AACK) && rw_q) ||
                                  ((state == ST_TACK) && mack_q));
  assign tx_take   = (tx_need || (state == ST_THOLD)) && tx_full;
  assign rx_done   = (state == ST_RX) && byte_done;
  assign rx_push   = (rx_done || (state == ST_RHOLD)) && !rxne;
  assign rx_byte   = sr;
  assign nack_evt  = (state == ST_TACK) && scl_fall && !mack_q;
  assign stop_evt  = stop_det && active;
  assign stall     = (state == ST_RHOLD) || (state == ST_THOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      sr     <= '0;
      cnt    <= '0;
      rw_q   <= 1'b0;
      mack_q <= 1'b0;
      active <= 1'b0;
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start_det) begin
      state  <= ST_ADDR;
      cnt    <= '0;
      active <= 1'b0;
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      active <= 1'b0;
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        ST_ADDR: begin
          if (scl_rise) begin
            sr  <= {sr[DATA_W-2:0], sda_s};
            cnt <= cnt + 1'b1;
          end else if (byte_done) begin
            if (hit && ack_en) begin
              sda_oe <= 1'b1;
              rw_q   <= sr[0];
              active <= 1'b1;
              state  <= ST_AACK;
            end else begin
              state <= ST_IGNORE;
            end
          end
        end
        ST_AACK, ST_TACK: begin
          if (state == ST_TACK && scl_rise) begin
            mack_q <= ~sda_s;
          end else if (scl_fall) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            if (tx_need) begin
              if (tx_full) begin
                sr     <= tx_byte;
                sda_oe <= ~tx_byte[DATA_W-1];
                state  <= ST_TX;
              end else begin
                scl_oe <= 1'b1;
                state  <= ST_THOLD;
              end
            end else if (state == ST_AACK) begin
              state <= ST_RX;
            end else begin
              state <= ST_IGNORE;
            end
          end
        end
        ST_THOLD: begin
          if (tx_full) begin
            sr     <= tx_byte;
            sda_oe <= ~tx_byte[DATA_W-1];
            scl_oe <= 1'b0;
            cnt    <= '0;
            state  <= ST_TX;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt == CNT_LAST) begin
              sda_oe <= 1'b0;
              state  <= ST_TACK;
            end else begin
              sr     <= sr << 1;
              sda_oe <= ~sr[DATA_W-2];
              cnt    <= cnt + 1'b1;
            end
          end
        end
        ST_RX: begin
          if (scl_rise) begin
            sr  <= {sr[DATA_W-2:0], sda_s};
            cnt <= cnt + 1'b1;
          end else if (byte_done) begin
            if (!rxne) begin
              sda_oe <= ack_en;
              state  <= ST_RACK;
            end else begin
              scl_oe <= 1'b1;
              state  <= ST_RHOLD;
            end
          end
        end
        ST_RHOLD: begin
          if (!rxne) begin
            sda_oe <= ack_en;
            scl_oe <= 1'b0;
            state  <= ST_RACK;
          end
        end
        ST_RACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            state  <= ST_RX;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_slv_flags.sv
module i2c_slv_flags #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_evt,
  input  logic              addr_rw,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              tx_take,
  input  logic              nack_evt,
  input  logic              stop_evt,
  input  logic              stall,
  input  logic              stat_rd,
  input  logic              rx_rd,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_din,
  input  logic              evt_ie,
  output logic [DATA_W-1:0] rx_dout,
  output logic [DATA_W-1:0] tx_byte,
  output logic              tx_full,
  output logic              flag_addr,
  output logic              flag_tra,
  output logic              flag_txe,
  output logic              flag_rxne,
  output logic              flag_af,
  output logic              flag_stopf,
  output logic              flag_btf,
  output logic              evt_irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_addr  <= 1'b0;
      flag_tra   <= 1'b0;
      flag_rxne  <= 1'b0;
      flag_af    <= 1'b0;
      flag_stopf <= 1'b0;
      tx_full    <= 1'b0;
      rx_dout    <= '0;
      tx_byte    <= '0;
    end else begin
      if (addr_evt)     flag_addr <= 1'b1;
      else if (stat_rd) flag_addr <= 1'b0;

      if (nack_evt)     flag_af <= 1'b1;
      else if (stat_rd) flag_af <= 1'b0;

      if (stop_evt)     flag_stopf <= 1'b1;
      else if (stat_rd) flag_stopf <= 1'b0;

      if (addr_evt)      flag_tra <= addr_rw;
      else if (stop_evt) flag_tra <= 1'b0;

      if (rx_push) begin
        flag_rxne <= 1'b1;
        rx_dout   <= rx_byte;
      end else if (rx_rd) begin
        flag_rxne <= 1'b0;
      end

      if (tx_wr) begin
        tx_full <= 1'b1;
        tx_byte <= tx_din;
      end else if (tx_take || stop_evt) begin
        tx_full <= 1'b0;
      end
    end
  end

  assign flag_txe = flag_tra & ~tx_full;
  assign flag_btf = stall;
  assign evt_irq  = evt_ie & (flag_addr | flag_rxne | flag_txe | flag_stopf | flag_af);
endmodule

// File: rtl/i2c_slave_ctrl.sv
module i2c_slave_ctrl #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic [DATA_W-2:0] own_addr,
  input  logic              ack_en,
  input  logic              gc_en,
  input  logic              evt_ie,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_din,
  input  logic              rx_rd,
  output logic [DATA_W-1:0] rx_dout,
  input  logic              stat_rd,
  output logic              flag_addr,
  output logic              flag_tra,
  output logic              flag_txe,
  output logic              flag_rxne,
  output logic              flag_af,
  output logic              flag_stopf,
  output logic              flag_btf,
  output logic              evt_irq
);
  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              addr_evt, addr_rw, rx_push, tx_take, nack_evt, stop_evt, stall;
  logic              tx_full;
  logic [DATA_W-1:0] rx_byte, tx_byte;

  i2c_slv_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_slv_engine #(.DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .own_addr(own_addr), .ack_en(ack_en), .gc_en(gc_en),
    .tx_full(tx_full), .tx_byte(tx_byte), .rxne(flag_rxne),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .addr_evt(addr_evt), .addr_rw(addr_rw),
    .rx_push(rx_push), .rx_byte(rx_byte), .tx_take(tx_take),
    .nack_evt(nack_evt), .stop_evt(stop_evt), .stall(stall)
  );

  i2c_slv_flags #(.DATA_W(DATA_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .addr_evt(addr_evt), .addr_rw(addr_rw),
    .rx_push(rx_push), .rx_byte(rx_byte), .tx_take(tx_take),
    .nack_evt(nack_evt), .stop_evt(stop_evt), .stall(stall),
    .stat_rd(stat_rd), .rx_rd(rx_rd), .tx_wr(tx_wr), .tx_din(tx_din),
    .evt_ie(evt_ie), .rx_dout(rx_dout), .tx_byte(tx_byte), .tx_full(tx_full),
    .flag_addr(flag_addr), .flag_tra(flag_tra), .flag_txe(flag_txe),
    .flag_rxne(flag_rxne), .flag_af(flag_af), .flag_stopf(flag_stopf),
    .flag_btf(flag_btf), .evt_irq(evt_irq)
  );
endmodule

// File: rtl/i2c_slave_ctrl_chk.sv
module i2c_slave_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_oe,
  input logic sda_oe,
  input logic scl_s,
  input logic start_det,
  input logic stop_det,
  input logic ack_en,
  input logic evt_ie,
  input logic stat_rd,
  input logic addr_evt,
  input logic flag_addr,
  input logic flag_tra,
  input logic flag_txe,
  input logic flag_rxne,
  input logic flag_af,
  input logic evt_irq
);
  assert_sda_on_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> (!$past(scl_s) || $past(start_det) || $past(stop_det)));

  assert_addr_needs_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_addr) |-> ack_en);

  assert_af_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_af) |-> !sda_oe);

  assert_rx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_oe && !flag_tra) |-> $past(flag_rxne));

  assert_tx_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_oe && flag_tra) |-> $past(flag_txe));

  assert_irq_on_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_ie && (flag_addr || flag_rxne)) |-> evt_irq);

  assert_irq_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_ie |-> !evt_irq);

  assert_set_wins_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_evt && stat_rd) |=> flag_addr);
endmodule

bind i2c_slave_ctrl i2c_slave_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe), .scl_s(scl_s),
  .start_det(start_det), .stop_det(stop_det), .ack_en(ack_en), .evt_ie(evt_ie),
  .stat_rd(stat_rd), .addr_evt(addr_evt), .flag_addr(flag_addr),
  .flag_tra(flag_tra), .flag_txe(flag_txe), .flag_rxne(flag_rxne),
  .flag_af(flag_af), .evt_irq(evt_irq)
);

// File: tb/tb_i2c_slave_ctrl.sv
module tb_i2c_slave_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam logic [6:0] OWN = 7'h3A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_oe, sda_oe;
  logic [6:0] own_addr = OWN;
  logic ack_en = 1'b1, gc_en = 1'b0, evt_ie = 1'b1;
  logic tx_wr = 1'b0, rx_rd = 1'b0, stat_rd = 1'b0;
  logic [7:0] tx_din = '0, rx_dout;
  logic flag_addr, flag_tra, flag_txe, flag_rxne, flag_af, flag_stopf, flag_btf, evt_irq;
  logic scl_bus, sda_bus;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  assign scl_bus = m_scl & ~scl_oe;
  assign sda_bus = m_sda & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_slave_ctrl dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(own_addr), .ack_en(ack_en),
    .gc_en(gc_en), .evt_ie(evt_ie), .tx_wr(tx_wr), .tx_din(tx_din),
    .rx_rd(rx_rd), .rx_dout(rx_dout), .stat_rd(stat_rd),
    .flag_addr(flag_addr), .flag_tra(flag_tra), .flag_txe(flag_txe),
    .flag_rxne(flag_rxne), .flag_af(flag_af), .flag_stopf(flag_stopf),
    .flag_btf(flag_btf), .evt_irq(evt_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic scl_up();
    m_scl = 1'b1;
    @(negedge clk);
    while (!scl_bus) @(negedge clk);
    waitq();
  endtask

  task automatic bus_start();
    m_sda = 1'b1; m_scl = 1'b1; waitq();
    m_sda = 1'b0; waitq();
    m_scl = 1'b0; waitq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; waitq();
    m_scl = 1'b1; waitq();
    m_sda = 1'b1; waitq();
  endtask

  task automatic send_byte(input logic [7:0] b, input bit collide, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; waitq();
      scl_up();
      m_scl = 1'b0;
      if (collide && i == 0) begin
        repeat (2) @(negedge clk);
        chk("R13 addr flag before edge", flag_addr, 0);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        chk("R13 addr flag survives read", flag_addr, 1);
      end
      waitq();
    end
    m_sda = 1'b1; waitq();
    scl_up();
    acked = (sda_bus == 1'b0);
    m_scl = 1'b0; waitq();
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit mack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; waitq();
      scl_up();
      b[i] = sda_bus;
      m_scl = 1'b0;
    end
    m_sda = ~mack; waitq();
    scl_up();
    m_scl = 1'b0; waitq();
    m_sda = 1'b1;
  endtask

  task automatic pulse_stat();
    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0; @(negedge clk);
  endtask

  task automatic pulse_rx();
    rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0; @(negedge clk);
  endtask

  task automatic write_tx(input logic [7:0] b);
    tx_din = b; tx_wr = 1'b1; @(negedge clk); tx_wr = 1'b0; @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] rb;
    repeat (3) @(negedge clk);
    chk("R1 flags", {flag_addr, flag_tra, flag_txe, flag_rxne, flag_af, flag_stopf, flag_btf, evt_irq}, 0);
    chk("R1 drives", {scl_oe, sda_oe}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after release", {flag_addr, scl_oe, sda_oe, evt_irq}, 0);

    // write transaction with status-read collision on the match edge
    bus_start();
    send_byte({OWN, 1'b0}, 1'b1, ack);
    chk("R2 address ack", ack, 1);
    chk("R2 addr flag", flag_addr, 1);
    chk("R2 tra receive", flag_tra, 0);
    chk("R12 irq on match", evt_irq, 1);
    pulse_stat();
    chk("R7 stat clears addr", flag_addr, 0);
    chk("R12 irq idle", evt_irq, 0);
    send_byte(8'hA5, 1'b0, ack);
    chk("R6 data ack", ack, 1);
    chk("R6 rxne", flag_rxne, 1);
    chk("R6 rx data", rx_dout, 8'hA5);
    fork
      send_byte(8'h3C, 1'b0, ack);
      begin
        while (!scl_oe) @(negedge clk);
        chk("R10 btf during hold", flag_btf, 1);
        chk("R10 held byte kept", rx_dout, 8'hA5);
        repeat (20) @(negedge clk);
        chk("R10 scl held low", scl_bus, 0);
        rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0;
      end
    join
    chk("R10 ack after release", ack, 1);
    chk("R10 btf cleared", flag_btf, 0);
    chk("R6 second byte", rx_dout, 8'h3C);
    pulse_rx();
    chk("R6 rx_rd clears rxne", flag_rxne, 0);
    ack_en = 1'b0;
    send_byte(8'h11, 1'b0, ack);
    chk("R6 nack with ack_en low", ack, 0);
    chk("R6 byte still delivered", rx_dout, 8'h11);
    pulse_rx();
    ack_en = 1'b1;
    bus_stop();
    chk("R7 stopf", flag_stopf, 1);
    chk("R7 tra cleared", flag_tra, 0);
    pulse_stat();
    chk("R7 stat clears stopf", flag_stopf, 0);

    // foreign address
    bus_start();
    send_byte({7'h12, 1'b0}, 1'b0, ack);
    chk("R3 address nack", ack, 0);
    chk("R3 no addr flag", flag_addr, 0);
    send_byte(8'h55, 1'b0, ack);
    chk("R3 data ignored", ack, 0);
    chk("R3 no rxne", flag_rxne, 0);
    bus_stop();
    chk("R3 no stopf", flag_stopf, 0);

    // ack disabled
    ack_en = 1'b0;
    bus_start();
    send_byte({OWN, 1'b0}, 1'b0, ack);
    chk("R4 address nack", ack, 0);
    chk("R4 no addr flag", flag_addr, 0);
    send_byte(8'h66, 1'b0, ack);
    chk("R4 rest ignored", {ack, flag_rxne}, 0);
    bus_stop();
    chk("R4 no stopf", flag_stopf, 0);
    ack_en = 1'b1;

    // broadcast address
    bus_start();
    send_byte(8'h00, 1'b0, ack);
    chk("R5 broadcast refused", {ack, flag_addr}, 0);
    bus_stop();
    gc_en = 1'b1;
    bus_start();
    send_byte(8'h00, 1'b0, ack);
    chk("R5 broadcast accepted", {ack, flag_addr, flag_tra}, 3'b110);
    bus_stop();
    pulse_stat();
    gc_en = 1'b0;

    // transmit
    write_tx(8'hC3);
    chk("R8 txe low outside transmit", flag_txe, 0);
    bus_start();
    send_byte({OWN, 1'b1}, 1'b0, ack);
    chk("R2 read address ack", ack, 1);
    chk("R2 tra transmit", flag_tra, 1);
    chk("R8 txe after load", flag_txe, 1);
    write_tx(8'h5E);
    chk("R8 write clears txe", flag_txe, 0);
    recv_byte(rb, 1'b1);
    chk("R8 first byte", rb, 8'hC3);
    chk("R8 txe after second load", flag_txe, 1);
    recv_byte(rb, 1'b0);
    chk("R8 second byte", rb, 8'h5E);
    chk("R9 af set", flag_af, 1);
    chk("R9 sda released", sda_oe, 0);
    bus_stop();
    chk("R7 stopf after transmit", {flag_stopf, flag_tra}, 2'b10);
    pulse_stat();
    chk("R7 stat clears af", flag_af, 0);

    // transmit stretch, interrupt masked
    evt_ie = 1'b0;
    bus_start();
    send_byte({OWN, 1'b1}, 1'b0, ack);
    chk("R12 irq masked", {flag_addr, evt_irq}, 2'b10);
    chk("R11 btf and txe", {flag_btf, flag_txe}, 2'b11);
    repeat (20) @(negedge clk);
    chk("R11 scl held", scl_oe, 1);
    write_tx(8'h96);
    @(negedge clk);
    chk("R11 released", {scl_oe, flag_btf}, 0);
    recv_byte(rb, 1'b0);
    chk("R11 byte after stretch", rb, 8'h96);
    bus_stop();
    pulse_stat();
    evt_ie = 1'b1;

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule